// File: doc/BRIEF.md
# Sixteen-bit evaluation stack unit

This block is the operand stack of a stack-machine datapath. It holds up to eight sixteen-bit two's-complement words in a small register file. Each cycle with `cmd_valid` high it carries out one command: it pushes a value, discards or recovers the top entry, rearranges the top entries, or runs a single-word or double-word arithmetic or logic operation. The operands are read from the stack and the result is written back in their place. The two top entries and the depth are always visible on the outputs, so the surrounding datapath can read its operands without issuing a command.

A double word uses two adjacent entries. Its less significant half is in the lower entry and its more significant half in the entry above it. So after a double-word result, `top0` holds the high half and `top1` holds the low half. Discarding the top entry only moves the stack pointer. The discarded word stays in storage, and a later recover makes it visible again. Any command that would read below the bottom of the stack, or grow the stack past eight entries, is refused as a whole. A refused command raises a sticky flag and leaves the stack unchanged.

Top module: `evstack_unit`

## Requirements
- R1: While reset is asserted and after it is released, `depth` is 0, `top0` and `top1` are 0, both flags are 0 and `spill_valid` is 0.
- R2: Command code 1 (push) places `push_data` on top and raises the depth by one. `top0` shows the top entry and `top1` the entry below it, and a position that does not hold an entry reads as 0.
- R3: Code 2 (discard) lowers the depth by one and leaves storage untouched. Code 3 (recover) raises the depth by one without writing, so the word left at that position reappears. The cycle after a discard, `spill_valid` is 1 and `spill_word` holds the removed word.
- R4: Code 4 swaps the top two entries. Code 5 swaps the top two double words, each double word being a pair of entries.
- R5: Code 6 duplicates the top entry (depth +1). Code 7 duplicates the top double word (depth +2, same high/low order).
- R6: The following codes replace the top entry modulo 2^16: code 8 doubles it (shift left by one), code 15 negates it, code 16 increments it and code 17 decrements it.
- R7: Each binary code takes the entry below the top as operand A and the top as operand B, and replaces both with one result (depth −1). The codes are: 9 gives A+B, 10 gives A−B, 11 gives the low 16 bits of A·B, 12 gives A|B, 13 gives A&B and 14 gives A^B.
- R8: Codes 18 and 19 treat the top pair as 32-bit value B and the pair below it as 32-bit value A. In each pair the low half is the lower entry. They leave A+B or A−B modulo 2^32 as one double word (depth −2).
- R9: Code 20 (store-and-keep) leaves the depth and all entries unchanged. The next cycle, `spill_valid` is 1 and `spill_word` holds the top word.
- R10: A command that needs more entries than the depth holds leaves the stack unchanged and sets `unf_flag`. The flag stays set until reset. Entries needed per code: 2, 6, 8, 15–17 and 20 need 1; 4, 7 and 9–14 need 2; 5, 18 and 19 need 4.
- R11: A command whose result would exceed 8 entries leaves the stack unchanged and sets `ovf_flag`. The flag stays set until reset.
- R12: With `cmd_valid` low, or with code 0 or any code from 21 to 31, the stack, the depth and the flags are unchanged and `spill_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | Command code |
| push_data | input | 16 | Value for the push command |
| top0 | output | 16 | Top entry, 0 when empty |
| top1 | output | 16 | Entry below the top, 0 when depth < 2 |
| depth | output | 4 | Number of entries held |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| spill_valid | output | 1 | One-cycle strobe after a discard or store-and-keep |
| spill_word | output | 16 | Word removed or kept by that command |

## Verification
Every result of this block appears one clock edge after its command. The stack pointer, the storage, the flags and the spill register all load on the edge that accepts the command. `top0`, `top1` and `depth` are then read combinationally from that state. The driver applies a command on a falling edge and queues the state it expects after the next rising edge. The monitor samples one nanosecond after each rising edge and compares against the queue head, so each expectation is checked in exactly the cycle it becomes due.

// File: rtl/evstack_pkg.sv
package evstack_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [4:0] {
    OP_NOP     = 5'd0,
    OP_PUSH    = 5'd1,
    OP_DROP    = 5'd2,
    OP_RECOVER = 5'd3,
    OP_SWAP    = 5'd4,
    OP_DSWAP   = 5'd5,
    OP_COPY    = 5'd6,
    OP_DCOPY   = 5'd7,
    OP_TWICE   = 5'd8,
    OP_ADD     = 5'd9,
    OP_SUB     = 5'd10,
    OP_MUL     = 5'd11,
    OP_OR      = 5'd12,
    OP_AND     = 5'd13,
    OP_XOR     = 5'd14,
    OP_NEG     = 5'd15,
    OP_INC     = 5'd16,
    OP_DEC     = 5'd17,
    OP_DADD    = 5'd18,
    OP_DSUB    = 5'd19,
    OP_KEEP    = 5'd20
  } stk_op_e;

  // entries a command consumes before it may run
  function automatic int op_need(logic [4:0] op);
    case (op)
      OP_DROP, OP_COPY, OP_TWICE, OP_NEG, OP_INC, OP_DEC, OP_KEEP: return 1;
      OP_SWAP, OP_DCOPY, OP_ADD, OP_SUB, OP_MUL, OP_OR, OP_AND, OP_XOR: return 2;
      OP_DSWAP, OP_DADD, OP_DSUB: return 4;
      default: return 0;
    endcase
  endfunction

  // signed change of the depth when the command is accepted
  function automatic int op_net(logic [4:0] op);
    case (op)
      OP_PUSH, OP_RECOVER, OP_COPY: return 1;
      OP_DCOPY: return 2;
      OP_DROP, OP_ADD, OP_SUB, OP_MUL, OP_OR, OP_AND, OP_XOR: return -1;
      OP_DADD, OP_DSUB: return -2;
      default: return 0;
    endcase
  endfunction

  // a = entry below the top, b = top
  function automatic logic [WORD_W-1:0] f_binary(logic [4:0] op,
                                                 logic [WORD_W-1:0] a,
                                                 logic [WORD_W-1:0] b);
    logic [2*WORD_W-1:0] prod;
    prod = {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b};
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return prod[WORD_W-1:0];
      OP_OR:   return a | b;
      OP_AND:  return a & b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] f_unary(logic [4:0] op,
                                                logic [WORD_W-1:0] x);
    case (op)
      OP_TWICE: return {x[WORD_W-2:0], 1'b0};
      OP_NEG:   return ~x + 1'b1;
      OP_INC:   return x + 1'b1;
      default:  return x - 1'b1;
    endcase
  endfunction

  function automatic logic [2*WORD_W-1:0] f_dword(logic [4:0] op,
                                                  logic [2*WORD_W-1:0] a,
                                                  logic [2*WORD_W-1:0] b);
    if (op == OP_DSUB) return a - b;
    return a + b;
  endfunction

endpackage

// File: rtl/evstack_guard.sv
module evstack_guard
  import evstack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          valid,
  input  logic [4:0]    op,
  input  logic [CW-1:0] cur_depth,
  output logic          accept,
  output logic          unf_evt,
  output logic          ovf_evt,
  output logic [CW-1:0] next_depth
);

  int need;
  int after;

  always_comb begin
    need    = op_need(op);
    after   = int'(cur_depth) + op_net(op);
    unf_evt = valid && (int'(cur_depth) < need);
    ovf_evt = valid && !unf_evt && (after > DEPTH);
    accept  = valid && !unf_evt && !ovf_evt;
    next_depth = accept ? CW'(after) : cur_depth;
  end

endmodule

// File: rtl/evstack_exec.sv
module evstack_exec
  import evstack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W = WORD_W,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int NP = 4
) (
  input  logic                  accept,
  input  logic [4:0]            op,
  input  logic [W-1:0]          push_data,
  input  logic [CW-1:0]         sp,
  input  logic [NP-1:0][W-1:0]  rd,
  output logic [NP-1:0]         wr_en,
  output logic [NP-1:0][PW-1:0] wr_idx,
  output logic [NP-1:0][W-1:0]  wr_data
);

  function automatic logic [PW-1:0] slot(logic [CW-1:0] s, int off);
    int t;
    t = int'(s) + off;
    return PW'(t);
  endfunction

  logic [2*W-1:0] dres;

  always_comb begin
    wr_en   = '0;
    wr_idx  = '0;
    wr_data = '0;
    dres    = f_dword(op, {rd[2], rd[3]}, {rd[0], rd[1]});
    case (op)
      OP_PUSH: begin
        wr_en[0] = 1'b1; wr_idx[0] = slot(sp, 0); wr_data[0] = push_data;
      end
      OP_SWAP: begin
        wr_en[1:0] = 2'b11;
        wr_idx[0] = slot(sp, -1); wr_data[0] = rd[1];
        wr_idx[1] = slot(sp, -2); wr_data[1] = rd[0];
      end
      OP_DSWAP: begin
        wr_en = '1;
        wr_idx[0] = slot(sp, -1); wr_data[0] = rd[2];
        wr_idx[1] = slot(sp, -2); wr_data[1] = rd[3];
        wr_idx[2] = slot(sp, -3); wr_data[2] = rd[0];
        wr_idx[3] = slot(sp, -4); wr_data[3] = rd[1];
      end
      OP_COPY: begin
        wr_en[0] = 1'b1; wr_idx[0] = slot(sp, 0); wr_data[0] = rd[0];
      end
      OP_DCOPY: begin
        wr_en[1:0] = 2'b11;
        wr_idx[0] = slot(sp, 0); wr_data[0] = rd[1];
        wr_idx[1] = slot(sp, 1); wr_data[1] = rd[0];
      end
      OP_TWICE, OP_NEG, OP_INC, OP_DEC: begin
        wr_en[0] = 1'b1; wr_idx[0] = slot(sp, -1);
        wr_data[0] = f_unary(op, rd[0]);
      end
      OP_ADD, OP_SUB, OP_MUL, OP_OR, OP_AND, OP_XOR: begin
        wr_en[0] = 1'b1; wr_idx[0] = slot(sp, -2);
        wr_data[0] = f_binary(op, rd[1], rd[0]);
      end
      OP_DADD, OP_DSUB: begin
        wr_en[1:0] = 2'b11;
        wr_idx[0] = slot(sp, -4); wr_data[0] = dres[W-1:0];
        wr_idx[1] = slot(sp, -3); wr_data[1] = dres[2*W-1:W];
      end
      default: ;
    endcase
    if (!accept) wr_en = '0;
  end

endmodule

// File: rtl/evstack_regs.sv
module evstack_regs
  import evstack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W = WORD_W,
  parameter int NP = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         sp_next,
  input  logic [NP-1:0]         wr_en,
  input  logic [NP-1:0][PW-1:0] wr_idx,
  input  logic [NP-1:0][W-1:0]  wr_data,
  output logic [CW-1:0]         sp,
  output logic [NP-1:0][W-1:0]  rd
);

  logic [DEPTH-1:0][W-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
      sp  <= '0;
    end else begin
      sp <= sp_next;
      for (int p = 0; p < NP; p++) begin
        if (wr_en[p]) mem[wr_idx[p]] <= wr_data[p];
      end
    end
  end

  // rd[k] is the entry k places below the top, zero when absent
  for (genvar k = 0; k < NP; k++) begin : g_rd
    logic [CW-1:0] pos;
    assign pos   = sp - CW'(k + 1);
    assign rd[k] = (sp > CW'(k)) ? mem[pos[PW-1:0]] : '0;
  end

endmodule

// File: rtl/evstack_unit.sv
module evstack_unit
  import evstack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W = WORD_W,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [4:0]    cmd_op,
  input  logic [W-1:0]  push_data,
  output logic [W-1:0]  top0,
  output logic [W-1:0]  top1,
  output logic [CW-1:0] depth,
  output logic          ovf_flag,
  output logic          unf_flag,
  output logic          spill_valid,
  output logic [W-1:0]  spill_word
);

  localparam int NP = 4;
  localparam int PW = $clog2(DEPTH);

  logic                  accept_evt;
  logic                  unf_evt;
  logic                  ovf_evt;
  logic                  reject_evt;
  logic                  spill_evt;
  logic [CW-1:0]         sp;
  logic [CW-1:0]         sp_next;
  logic [NP-1:0][W-1:0]  rd;
  logic [NP-1:0]         wr_en;
  logic [NP-1:0][PW-1:0] wr_idx;
  logic [NP-1:0][W-1:0]  wr_data;

  evstack_guard #(.DEPTH(DEPTH)) u_guard (
    .valid      (cmd_valid),
    .op         (cmd_op),
    .cur_depth  (sp),
    .accept     (accept_evt),
    .unf_evt    (unf_evt),
    .ovf_evt    (ovf_evt),
    .next_depth (sp_next)
  );

  evstack_exec #(.DEPTH(DEPTH), .W(W)) u_exec (
    .accept    (accept_evt),
    .op        (cmd_op),
    .push_data (push_data),
    .sp        (sp),
    .rd        (rd),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  evstack_regs #(.DEPTH(DEPTH), .W(W), .NP(NP)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sp_next (sp_next),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .sp      (sp),
    .rd      (rd)
  );

  assign reject_evt = unf_evt | ovf_evt;
  assign spill_evt  = accept_evt && (cmd_op == OP_DROP || cmd_op == OP_KEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag    <= 1'b0;
      unf_flag    <= 1'b0;
      spill_valid <= 1'b0;
      spill_word  <= '0;
    end else begin
      if (ovf_evt) ovf_flag <= 1'b1;
      if (unf_evt) unf_flag <= 1'b1;
      spill_valid <= spill_evt;
      if (spill_evt) spill_word <= rd[0];
    end
  end

  assign top0  = rd[0];
  assign top1  = rd[1];
  assign depth = sp;

endmodule

// File: rtl/evstack_unit_chk.sv
module evstack_unit_chk
  import evstack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W = WORD_W,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [4:0]    cmd_op,
  input logic [W-1:0]  top0,
  input logic [W-1:0]  top1,
  input logic [CW-1:0] depth,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          spill_valid,
  input logic [W-1:0]  spill_word,
  input logic          accept_evt,
  input logic          reject_evt,
  input logic          unf_evt,
  input logic          ovf_evt
);

  // R10
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> unf_flag);

  // R10
  unf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> unf_flag);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R11
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> $stable(depth) && $stable(top0) && $stable(top1));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(depth) && $stable(top0) && !spill_valid);

  // R3
  drop_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && cmd_op == OP_DROP) |=>
      spill_valid && spill_word == $past(top0) && depth == $past(depth) - 1'b1);

  // R9
  keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && cmd_op == OP_KEEP) |=> $stable(depth) && $stable(top0) && spill_valid);

endmodule

bind evstack_unit evstack_unit_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .top0        (top0),
  .top1        (top1),
  .depth       (depth),
  .ovf_flag    (ovf_flag),
  .unf_flag    (unf_flag),
  .spill_valid (spill_valid),
  .spill_word  (spill_word),
  .accept_evt  (accept_evt),
  .reject_evt  (reject_evt),
  .unf_evt     (unf_evt),
  .ovf_evt     (ovf_evt)
);

// File: tb/test_evstack_unit.sv
`timescale 1ns/1ps
module test_evstack_unit;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [4:0]  cmd_op = '0;
  logic [15:0] push_data = '0;
  logic [15:0] top0, top1, spill_word;
  logic [3:0]  depth;
  logic        ovf_flag, unf_flag, spill_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  evstack_unit i_evstack_unit (
    .clk, .rst_n, .cmd_valid, .cmd_op, .push_data,
    .top0, .top1, .depth, .ovf_flag, .unf_flag, .spill_valid, .spill_word
  );

  always #2 clk = ~clk;

  // reference model state
  logic [15:0] m [N];
  int sp = 0;
  bit movf = 0, munf = 0;
  logic [15:0] mspill = '0;

  typedef struct {
    logic [15:0] t0, t1, sw;
    int d;
    bit o, u, sv;
    string tag;
  } exp_t;
  exp_t q[$];

  function automatic logic [15:0] at(int k);
    return (sp > k) ? m[sp-1-k] : 16'h0;
  endfunction

  task automatic model(input bit v, input logic [4:0] op, input logic [15:0] d,
                       output bit sv);
    int need, net;
    logic [31:0] a32, b32, r32;
    logic [15:0] a, b;
    sv = 0;
    if (!v) return;
    case (op)
      1:  begin need = 0; net = 1; end
      2:  begin need = 1; net = -1; end
      3:  begin need = 0; net = 1; end
      4:  begin need = 2; net = 0; end
      5:  begin need = 4; net = 0; end
      6:  begin need = 1; net = 1; end
      7:  begin need = 2; net = 2; end
      8, 15, 16, 17, 20: begin need = 1; net = 0; end
      9, 10, 11, 12, 13, 14: begin need = 2; net = -1; end
      18, 19: begin need = 4; net = -2; end
      default: begin need = 0; net = 0; end
    endcase
    if (sp < need) begin munf = 1; return; end
    if (sp + net > N) begin movf = 1; return; end
    b = at(0); a = at(1);
    case (op)
      1: m[sp] = d;
      2: begin sv = 1; mspill = b; end
      4: begin m[sp-1] = a; m[sp-2] = b; end
      5: begin
        logic [15:0] h, l;
        h = m[sp-1]; l = m[sp-2];
        m[sp-1] = m[sp-3]; m[sp-2] = m[sp-4]; m[sp-3] = h; m[sp-4] = l;
      end
      6: m[sp] = b;
      7: begin m[sp] = a; m[sp+1] = b; end
      8:  m[sp-1] = b << 1;
      15: m[sp-1] = 16'h0 - b;
      16: m[sp-1] = b + 16'h1;
      17: m[sp-1] = b - 16'h1;
      9:  m[sp-2] = a + b;
      10: m[sp-2] = a - b;
      11: begin r32 = {16'h0, a} * {16'h0, b}; m[sp-2] = r32[15:0]; end
      12: m[sp-2] = a | b;
      13: m[sp-2] = a & b;
      14: m[sp-2] = a ^ b;
      18, 19: begin
        a32 = {m[sp-3], m[sp-4]}; b32 = {m[sp-1], m[sp-2]};
        r32 = (op == 18) ? a32 + b32 : a32 - b32;
        m[sp-3] = r32[31:16]; m[sp-4] = r32[15:0];
      end
      20: begin sv = 1; mspill = b; end
      default: ;
    endcase
    sp = sp + net;
  endtask

  task automatic issue(input bit v, input logic [4:0] op, input logic [15:0] d,
                       input string tag);
    exp_t e;
    bit sv;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; push_data = d;
    model(v, op, d, sv);
    e.t0 = at(0); e.t1 = at(1); e.d = sp; e.o = movf; e.u = munf;
    e.sv = sv; e.sw = mspill; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmd(input logic [4:0] op, input logic [15:0] d, input string tag);
    issue(1'b1, op, d, tag);
  endtask

  function automatic string tag_of(logic [4:0] op);
    case (op)
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6, 7: return "R5";
      8, 15, 16, 17: return "R6";
      9, 10, 11, 12, 13, 14: return "R7";
      18, 19: return "R8";
      20: return "R9";
      default: return "R12";
    endcase
  endfunction

  // monitor: one expectation per command, due one edge later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (top0 !== e.t0 || top1 !== e.t1 || int'(depth) != e.d ||
            ovf_flag !== e.o || unf_flag !== e.u || spill_valid !== e.sv ||
            (e.sv && spill_word !== e.sw)) begin
          failures++;
          $display("FAIL %s actual t0=%h t1=%h d=%0d o=%b u=%b sv=%b sw=%h expected t0=%h t1=%h d=%0d o=%b u=%b sv=%b sw=%h",
                   e.tag, top0, top1, depth, ovf_flag, unf_flag, spill_valid, spill_word,
                   e.t0, e.t1, e.d, e.o, e.u, e.sv, e.sw);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clear(input string tag);
    while (sp > 0) cmd(2, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) m[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (top0 !== 0 || top1 !== 0 || depth !== 0 || ovf_flag !== 0 ||
        unf_flag !== 0 || spill_valid !== 0) begin
      failures++;
      $display("FAIL R1 actual t0=%h t1=%h d=%0d o=%b u=%b sv=%b expected all zero",
               top0, top1, depth, ovf_flag, unf_flag, spill_valid);
    end
    rst_n = 1'b1;

    // R12 idle, no-op and unassigned codes
    issue(1'b0, 5'd1, 16'h1234, "R12");
    cmd(0, 16'h1111, "R12");
    cmd(25, 16'h2222, "R12");

    // R2 / R7
    cmd(1, 16'h0005, "R2"); cmd(1, 16'h0003, "R2"); cmd(10, 0, "R7");
    cmd(1, 16'h0007, "R2"); cmd(11, 0, "R7");
    cmd(1, 16'h1234, "R2"); cmd(1, 16'h0100, "R2"); cmd(11, 0, "R7");
    cmd(1, 16'hF0F0, "R2"); cmd(12, 0, "R7");
    cmd(1, 16'h0FF0, "R2"); cmd(13, 0, "R7");
    cmd(1, 16'h5555, "R2"); cmd(14, 0, "R7");
    cmd(9, 0, "R7");
    cmd(1, 16'h0001, "R2"); cmd(10, 0, "R7");

    // R6
    cmd(8, 0, "R6"); cmd(1, 16'h8001, "R2"); cmd(8, 0, "R6");
    cmd(15, 0, "R6"); cmd(16, 0, "R6"); cmd(17, 0, "R6");
    cmd(1, 16'h0000, "R2"); cmd(17, 0, "R6"); cmd(16, 0, "R6"); cmd(15, 0, "R6");
    cmd(1, 16'hFFFF, "R2"); cmd(16, 0, "R6");
    clear("R3");

    // R4 / R5
    cmd(1, 16'hA001, "R2"); cmd(1, 16'hA002, "R2");
    cmd(1, 16'hA003, "R2"); cmd(1, 16'hA004, "R2");
    cmd(4, 0, "R4"); cmd(5, 0, "R4"); cmd(2, 0, "R3"); cmd(2, 0, "R3");
    cmd(6, 0, "R5"); cmd(7, 0, "R5"); cmd(2, 0, "R3"); cmd(2, 0, "R3");
    clear("R3");

    // R3 storage survives a discard
    cmd(1, 16'hC001, "R2"); cmd(1, 16'hC002, "R2"); cmd(1, 16'hC003, "R2");
    cmd(2, 0, "R3"); cmd(2, 0, "R3"); cmd(3, 0, "R3"); cmd(3, 0, "R3");
    cmd(2, 0, "R3"); cmd(1, 16'hC0DE, "R2"); cmd(2, 0, "R3"); cmd(3, 0, "R3");
    clear("R3");

    // R8 double words: low half pushed first
    cmd(1, 16'hFFFF, "R2"); cmd(1, 16'h0001, "R2");
    cmd(1, 16'h0001, "R2"); cmd(1, 16'h0000, "R2");
    cmd(18, 0, "R8");
    cmd(1, 16'h0003, "R2"); cmd(1, 16'h0000, "R2"); cmd(19, 0, "R8");
    cmd(1, 16'h0000, "R2"); cmd(1, 16'h0000, "R2");
    cmd(1, 16'h0001, "R2"); cmd(1, 16'h0000, "R2"); cmd(19, 0, "R8");

    // R9
    cmd(20, 0, "R9"); cmd(20, 0, "R9");
    clear("R3");

    // R10 underflow
    cmd(2, 0, "R10"); cmd(20, 0, "R10");
    cmd(1, 16'h0042, "R2"); cmd(4, 0, "R10"); cmd(9, 0, "R10");
    cmd(1, 16'h0043, "R2"); cmd(1, 16'h0044, "R2"); cmd(18, 0, "R10"); cmd(5, 0, "R10");

    // R11 overflow
    while (sp < N - 1) cmd(1, 16'h0100 + 16'(sp), "R2");
    cmd(7, 0, "R11");
    cmd(1, 16'h0777, "R2");
    cmd(1, 16'h0888, "R11"); cmd(3, 0, "R11"); cmd(6, 0, "R11");

    // R12 after flags are set
    issue(1'b0, 5'd2, 16'h0, "R12"); cmd(31, 0, "R12"); cmd(21, 0, "R12");
    clear("R3");

    // mixed stream
    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      op = 5'($urandom_range(0, 22));
      if (sp < 3 && ($urandom_range(0, 2) != 0)) op = 5'd1;
      issue(($urandom_range(0, 7) != 0), op, 16'($urandom), tag_of(op));
    end

    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule